// File: doc/BRIEF.md
# Privilege-Gated Thread-Pointer Register Slice

This block is a small slice of a system-control register bank. It holds one word that software uses as a thread pointer, together with a 32-bit enable mask that decides which hardware-register indices unprivileged code may read. Privileged software reaches both through a move-to/move-from port addressed by register number and select. The thread-pointer word lives at register 4, select 2, and the enable mask lives at register 7, select 0. The hardware never interprets the word. It stores whatever privileged code writes and returns it unchanged.

A second, user-level port reads hardware registers by index. Index 29 returns the thread-pointer word, and index 2 returns a free-running cycle counter. A user-port read succeeds when the core is in kernel mode or when the mask bit at the requested index is 1. Any other read raises a reserved-instruction fault and does not write the destination. A configuration input says whether the thread-pointer register is implemented. When it is not, privileged accesses to it read zero and drop writes, and user reads of index 29 fault.

The data width is a parameter, either 32 or 64. On a 64-bit build a narrow (32-bit) privileged access works on the low word, sign-extended.

Top module: `tls_regslice`

## Requirements
- R1: Synchronous reset clears the enable mask to zero and clears the thread-pointer word and the cycle counter. After reset a non-kernel user read of index 29 faults.
- R2: While `cfg_tp_present` is 0, a privileged read of register 4 select 2 returns zero without flagging invalid, and a privileged write there leaves the stored word unchanged.
- R3: While the register is present, a full-width privileged write to register 4 select 2 stores all bits, and a full-width read returns them unchanged. A write takes effect at the next clock edge.
- R4: On a 64-bit build, a privileged access with `pv_wide`=0 works on the low 32 bits sign-extended: a narrow write stores sext(wdata[31:0]) and a narrow read returns sext(word[31:0]).
- R5: A user read of index 29 returns the word with `ur_valid`=1 when the register is present and either `kernel_mode`=1 or mask bit 29 is 1.
- R6: A user read that is not permitted drives `ur_fault`=1, `ur_valid`=0 and `ur_rdata`=0.
- R7: The enable mask is written and read at register 7 select 0. Mask bit n gates user index n. A read returns the 32-bit mask sign-extended to the data width.
- R8: A privileged access to any other register or select, including register 4 select 1, raises `pv_invalid`, reads zero, and changes neither stored register.
- R9: A mask write changes user-port permission from the next cycle on. A user read in the same cycle as the write sees the old mask.
- R10: A user read of any index other than 2 and 29 faults, even in kernel mode with every mask bit set.
- R11: User index 2 returns the cycle counter, zero-extended. It is permitted by kernel mode or mask bit 2, and the counter advances by one every cycle.
- R12: With `ur_rd_en`=0, both `ur_valid` and `ur_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tp_present | input | 1 | 1 = thread-pointer register implemented |
| kernel_mode | input | 1 | 1 = core runs with system-control privileges |
| pv_rd_en | input | 1 | Privileged move-from request |
| pv_wr_en | input | 1 | Privileged move-to request |
| pv_regnum | input | 5 | Privileged register number |
| pv_sel | input | 3 | Privileged register select |
| pv_wide | input | 1 | 1 = full-width access, 0 = 32-bit access |
| pv_wdata | input | XLEN | Privileged write data |
| pv_rdata | output | XLEN | Privileged read data (combinational) |
| pv_invalid | output | 1 | Access targets no register of this slice |
| ur_rd_en | input | 1 | User hardware-register read request |
| ur_index | input | 5 | User hardware-register index |
| ur_rdata | output | XLEN | User read data |
| ur_valid | output | 1 | Read permitted; destination is written |
| ur_fault | output | 1 | Reserved-instruction fault |

## Verification
The bench targets the timing of a mask write that lands in the same cycle as a user read. A design that forwards the new mask would grant that read instead of faulting. It checks that an absent register reads zero and drops writes, where a careless design would either keep the data or flag the access invalid. It also checks that a narrow read of a value with bit 31 set comes back sign-extended, which a zero-extending design would get wrong. It walks a table of kernel, mask and index combinations, including index 30 and index 5 with every mask bit set. A design that indexed the mask loosely, or that let kernel mode open unimplemented indices, would return a valid result there.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

    localparam int unsigned REGNUM_W = 5;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned HWR_W    = 5;
    localparam int unsigned MASK_W   = 32;

    localparam logic [REGNUM_W-1:0] TP_REGNUM   = 5'd4;
    localparam logic [SEL_W-1:0]    TP_SEL      = 3'd2;
    localparam logic [REGNUM_W-1:0] MASK_REGNUM = 5'd7;
    localparam logic [SEL_W-1:0]    MASK_SEL    = 3'd0;

    localparam logic [HWR_W-1:0] HWR_TP_IDX = 5'd29;
    localparam logic [HWR_W-1:0] HWR_CC_IDX = 5'd2;

    typedef enum logic [1:0] {
        PV_NONE = 2'd0,
        PV_TP   = 2'd1,
        PV_MASK = 2'd2,
        PV_BAD  = 2'd3
    } pv_target_e;

    typedef enum logic [1:0] {
        UR_SRC_NONE = 2'd0,
        UR_SRC_TP   = 2'd1,
        UR_SRC_CC   = 2'd2
    } ur_src_e;

    typedef struct packed {
        logic    grant;
        logic    fault;
        ur_src_e src;
    } ur_resp_t;

    function automatic logic index_known(input logic [HWR_W-1:0] idx);
        return (idx == HWR_TP_IDX) || (idx == HWR_CC_IDX);
    endfunction

endpackage

// File: rtl/tlr_pv_decode.sv
module tlr_pv_decode
    import tlr_pkg::*;
(
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [REGNUM_W-1:0] regnum,
    input  logic [SEL_W-1:0]    sel,
    output pv_target_e          tgt
);
    always_comb begin
        tgt = PV_NONE;
        if (rd_en || wr_en) begin
            if (regnum == TP_REGNUM && sel == TP_SEL)
                tgt = PV_TP;
            else if (regnum == MASK_REGNUM && sel == MASK_SEL)
                tgt = PV_MASK;
            else
                tgt = PV_BAD;
        end
    end
endmodule

// File: rtl/tlr_narrow.sv
module tlr_narrow #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    input  logic            wide,
    output logic [XLEN-1:0] dout
);
    generate
        if (XLEN > 32) begin : g_wide
            assign dout = wide ? din : {{(XLEN-32){din[31]}}, din[31:0]};
        end else begin : g_narrow
            logic unused_wide;
            assign unused_wide = wide;
            assign dout        = din;
        end
    endgenerate
endmodule

// File: rtl/tlr_state.sv
module tlr_state
    import tlr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tp_we,
    input  logic [XLEN-1:0]   tp_wdata,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic [XLEN-1:0]   tp_q,
    output logic [MASK_W-1:0] mask_q,
    output logic [CNT_W-1:0]  cc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tp_q   <= '0;
            mask_q <= '0;
            cc_q   <= '0;
        end else begin
            cc_q <= cc_q + CNT_W'(1);
            if (tp_we)   tp_q   <= tp_wdata;
            if (mask_we) mask_q <= mask_wdata;
        end
    end
endmodule

// File: rtl/tlr_ur_gate.sv
module tlr_ur_gate
    import tlr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CNT_W = 32
) (
    input  logic              rd_en,
    input  logic [HWR_W-1:0]  idx,
    input  logic              kernel,
    input  logic              present,
    input  logic [MASK_W-1:0] mask_q,
    input  logic [XLEN-1:0]   tp_q,
    input  logic [CNT_W-1:0]  cc_q,
    output logic [XLEN-1:0]   rdata,
    output logic              valid,
    output logic              fault
);
    ur_resp_t resp;
    logic     allowed;
    logic     exists;

    always_comb begin
        exists  = index_known(idx) && ((idx != HWR_TP_IDX) || present);
        allowed = kernel || mask_q[idx];
        resp    = '{grant: 1'b0, fault: 1'b0, src: UR_SRC_NONE};
        if (rd_en) begin
            if (exists && allowed) begin
                resp.grant = 1'b1;
                resp.src   = (idx == HWR_TP_IDX) ? UR_SRC_TP : UR_SRC_CC;
            end else begin
                resp.fault = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (resp.src)
            UR_SRC_TP: rdata = tp_q;
            UR_SRC_CC: rdata = XLEN'(cc_q);
            default:   rdata = '0;
        endcase
    end

    assign valid = resp.grant;
    assign fault = resp.fault;
endmodule

// File: rtl/tls_regslice.sv
module tls_regslice
    import tlr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_tp_present,
    input  logic                kernel_mode,
    input  logic                pv_rd_en,
    input  logic                pv_wr_en,
    input  logic [REGNUM_W-1:0] pv_regnum,
    input  logic [SEL_W-1:0]    pv_sel,
    input  logic                pv_wide,
    input  logic [XLEN-1:0]     pv_wdata,
    output logic [XLEN-1:0]     pv_rdata,
    output logic                pv_invalid,
    input  logic                ur_rd_en,
    input  logic [HWR_W-1:0]    ur_index,
    output logic [XLEN-1:0]     ur_rdata,
    output logic                ur_valid,
    output logic                ur_fault
);
    localparam int unsigned MASK_PAD = XLEN - MASK_W;

    pv_target_e        tgt;
    logic [XLEN-1:0]   tp_q;
    logic [MASK_W-1:0] mask_q;
    logic [CNT_W-1:0]  cc_q;
    logic [XLEN-1:0]   tp_wdata_n;
    logic [XLEN-1:0]   tp_rdata_n;
    logic [XLEN-1:0]   mask_rdata_n;
    logic              tp_we;
    logic              mask_we;

    tlr_pv_decode u_dec (
        .rd_en  (pv_rd_en),
        .wr_en  (pv_wr_en),
        .regnum (pv_regnum),
        .sel    (pv_sel),
        .tgt    (tgt)
    );

    tlr_narrow #(.XLEN(XLEN)) u_wnar (
        .din  (pv_wdata),
        .wide (pv_wide),
        .dout (tp_wdata_n)
    );

    tlr_narrow #(.XLEN(XLEN)) u_rnar (
        .din  (tp_q),
        .wide (pv_wide),
        .dout (tp_rdata_n)
    );

    tlr_narrow #(.XLEN(XLEN)) u_mnar (
        .din  (XLEN'(mask_q)),
        .wide (1'b0),
        .dout (mask_rdata_n)
    );

    assign tp_we   = pv_wr_en && (tgt == PV_TP) && cfg_tp_present;
    assign mask_we = pv_wr_en && (tgt == PV_MASK);

    tlr_state #(.XLEN(XLEN), .CNT_W(CNT_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .tp_we      (tp_we),
        .tp_wdata   (tp_wdata_n),
        .mask_we    (mask_we),
        .mask_wdata (pv_wdata[MASK_W-1:0]),
        .tp_q       (tp_q),
        .mask_q     (mask_q),
        .cc_q       (cc_q)
    );

    always_comb begin
        pv_rdata = '0;
        if (pv_rd_en) begin
            unique case (tgt)
                PV_TP:   pv_rdata = cfg_tp_present ? tp_rdata_n : '0;
                PV_MASK: pv_rdata = mask_rdata_n;
                default: pv_rdata = '0;
            endcase
        end
    end

    assign pv_invalid = (tgt == PV_BAD);

    tlr_ur_gate #(.XLEN(XLEN), .CNT_W(CNT_W)) u_gate (
        .rd_en   (ur_rd_en),
        .idx     (ur_index),
        .kernel  (kernel_mode),
        .present (cfg_tp_present),
        .mask_q  (mask_q),
        .tp_q    (tp_q),
        .cc_q    (cc_q),
        .rdata   (ur_rdata),
        .valid   (ur_valid),
        .fault   (ur_fault)
    );

    if (MASK_PAD > XLEN) begin : g_bad_width
        initial $error("XLEN must be at least 32");
    end
endmodule

// File: rtl/tlr_checker.sv
module tlr_checker
    import tlr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CNT_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_tp_present,
    input logic                kernel_mode,
    input logic                pv_rd_en,
    input logic                pv_wr_en,
    input logic [REGNUM_W-1:0] pv_regnum,
    input logic [SEL_W-1:0]    pv_sel,
    input logic [XLEN-1:0]     pv_rdata,
    input logic                pv_invalid,
    input logic                ur_rd_en,
    input logic [HWR_W-1:0]    ur_index,
    input logic [XLEN-1:0]     ur_rdata,
    input logic                ur_valid,
    input logic                ur_fault,
    input logic [XLEN-1:0]     tp_q,
    input logic [MASK_W-1:0]   mask_q,
    input logic [CNT_W-1:0]    cc_q
);
    logic tp_addr;
    assign tp_addr = (pv_regnum == TP_REGNUM) && (pv_sel == TP_SEL);

    a_r1_mask_cleared: assert property (@(posedge clk)
        rst |=> (mask_q == '0));

    a_r2_absent_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (pv_rd_en && !cfg_tp_present && tp_addr) |-> (pv_rdata == '0 && !pv_invalid));

    a_r2_absent_drops_write: assert property (@(posedge clk) disable iff (rst)
        (pv_wr_en && !cfg_tp_present && tp_addr) |=> $stable(tp_q));

    a_r5_user_denied: assert property (@(posedge clk) disable iff (rst)
        (ur_rd_en && ur_index == HWR_TP_IDX && !kernel_mode && !mask_q[HWR_TP_IDX])
        |-> ur_fault);

    a_r6_fault_no_data: assert property (@(posedge clk) disable iff (rst)
        ur_fault |-> (!ur_valid && ur_rdata == '0));

    a_r8_invalid_no_effect: assert property (@(posedge clk) disable iff (rst)
        (pv_wr_en && pv_invalid) |=> ($stable(tp_q) && $stable(mask_q)));

    a_r10_unknown_faults: assert property (@(posedge clk) disable iff (rst)
        (ur_rd_en && ur_index != HWR_TP_IDX && ur_index != HWR_CC_IDX) |-> ur_fault);

    a_r11_counter_steps: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cc_q - $past(cc_q) == CNT_W'(1)));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ur_rd_en |-> (!ur_valid && !ur_fault));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ur_valid, ur_fault}));
endmodule

bind tls_regslice tlr_checker #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_tp_present (cfg_tp_present),
    .kernel_mode    (kernel_mode),
    .pv_rd_en       (pv_rd_en),
    .pv_wr_en       (pv_wr_en),
    .pv_regnum      (pv_regnum),
    .pv_sel         (pv_sel),
    .pv_rdata       (pv_rdata),
    .pv_invalid     (pv_invalid),
    .ur_rd_en       (ur_rd_en),
    .ur_index       (ur_index),
    .ur_rdata       (ur_rdata),
    .ur_valid       (ur_valid),
    .ur_fault       (ur_fault),
    .tp_q           (tp_q),
    .mask_q         (mask_q),
    .cc_q           (cc_q)
);

// File: tb/tb_tls_regslice.sv
module tb_tls_regslice;
    localparam int unsigned XLEN = 64;

    typedef struct packed {
        logic        kern;
        logic [31:0] mask;
        logic [4:0]  idx;
        logic        ok;
        logic        is_tp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h0000_0000, 5'd29, 1'b0, 1'b1},
        '{1'b1, 32'h0000_0000, 5'd29, 1'b1, 1'b1},
        '{1'b0, 32'h2000_0000, 5'd29, 1'b1, 1'b1},
        '{1'b0, 32'hDFFF_FFFF, 5'd29, 1'b0, 1'b1},
        '{1'b0, 32'h0000_0004, 5'd2,  1'b1, 1'b0},
        '{1'b0, 32'h2000_0000, 5'd2,  1'b0, 1'b0},
        '{1'b1, 32'h0000_0000, 5'd2,  1'b1, 1'b0},
        '{1'b1, 32'hFFFF_FFFF, 5'd5,  1'b0, 1'b0},
        '{1'b0, 32'hFFFF_FFFF, 5'd30, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_tp_present = 1'b1;
    logic            kernel_mode = 1'b0;
    logic            pv_rd_en = 1'b0;
    logic            pv_wr_en = 1'b0;
    logic [4:0]      pv_regnum = '0;
    logic [2:0]      pv_sel = '0;
    logic            pv_wide = 1'b1;
    logic [XLEN-1:0] pv_wdata = '0;
    logic [XLEN-1:0] pv_rdata;
    logic            pv_invalid;
    logic            ur_rd_en = 1'b0;
    logic [4:0]      ur_index = '0;
    logic [XLEN-1:0] ur_rdata;
    logic            ur_valid;
    logic            ur_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tls_regslice #(.XLEN(XLEN)) dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_tp_present (cfg_tp_present),
        .kernel_mode    (kernel_mode),
        .pv_rd_en       (pv_rd_en),
        .pv_wr_en       (pv_wr_en),
        .pv_regnum      (pv_regnum),
        .pv_sel         (pv_sel),
        .pv_wide        (pv_wide),
        .pv_wdata       (pv_wdata),
        .pv_rdata       (pv_rdata),
        .pv_invalid     (pv_invalid),
        .ur_rd_en       (ur_rd_en),
        .ur_index       (ur_index),
        .ur_rdata       (ur_rdata),
        .ur_valid       (ur_valid),
        .ur_fault       (ur_fault)
    );

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_ports();
        pv_rd_en = 1'b0; pv_wr_en = 1'b0; ur_rd_en = 1'b0;
    endtask

    task automatic pv_write(input logic [4:0] r, input logic [2:0] s, input logic w,
                            input logic [XLEN-1:0] d);
        @(negedge clk);
        pv_wr_en = 1'b1; pv_regnum = r; pv_sel = s; pv_wide = w; pv_wdata = d;
        @(posedge clk); #1;
        idle_ports();
    endtask

    task automatic pv_read(input logic [4:0] r, input logic [2:0] s, input logic w,
                           output logic [XLEN-1:0] d, output logic inv);
        @(negedge clk);
        pv_rd_en = 1'b1; pv_regnum = r; pv_sel = s; pv_wide = w;
        #5;
        d = pv_rdata; inv = pv_invalid;
        @(posedge clk); #1;
        idle_ports();
    endtask

    task automatic ur_read(input logic k, input logic [4:0] i, output logic [XLEN-1:0] d,
                           output logic v, output logic f);
        @(negedge clk);
        kernel_mode = k; ur_rd_en = 1'b1; ur_index = i;
        #5;
        d = ur_rdata; v = ur_valid; f = ur_fault;
        @(posedge clk); #1;
        idle_ports();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        logic [XLEN-1:0] d, d2;
        logic inv, v, f;
        localparam logic [XLEN-1:0] TPVAL = 64'h0123_4567_89AB_CDEF;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        pv_read(5'd7, 3'd0, 1'b1, d, inv);
        check(d == '0 && !inv, "R1 mask after reset", d, '0);
        ur_read(1'b0, 5'd29, d, v, f);
        check(f && !v, "R1 user read faults after reset", {62'd0, v, f}, 64'd1);

        // R12: idle user port
        @(negedge clk); #5;
        check(!ur_valid && !ur_fault, "R12 idle user port", {62'd0, ur_valid, ur_fault}, 64'd0);

        // R3: full-width store and read back
        pv_write(5'd4, 3'd2, 1'b1, TPVAL);
        pv_read(5'd4, 3'd2, 1'b1, d, inv);
        check(d == TPVAL && !inv, "R3 full-width read back", d, TPVAL);

        // R4: narrow read sign-extends bit 31
        pv_read(5'd4, 3'd2, 1'b0, d, inv);
        check(d == 64'hFFFF_FFFF_89AB_CDEF, "R4 narrow read", d, 64'hFFFF_FFFF_89AB_CDEF);

        // R4: narrow write stores sign-extended low word
        pv_write(5'd4, 3'd2, 1'b0, 64'hAAAA_BBBB_7000_0001);
        pv_read(5'd4, 3'd2, 1'b1, d, inv);
        check(d == 64'h0000_0000_7000_0001, "R4 narrow write", d, 64'h0000_0000_7000_0001);
        pv_write(5'd4, 3'd2, 1'b1, TPVAL);

        // R2: absent register reads zero and drops writes
        cfg_tp_present = 1'b0;
        pv_write(5'd4, 3'd2, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
        pv_read(5'd4, 3'd2, 1'b1, d, inv);
        check(d == '0 && !inv, "R2 absent read zero", d, '0);
        ur_read(1'b1, 5'd29, d, v, f);
        check(f && !v, "R2 absent user read faults", {62'd0, v, f}, 64'd1);
        cfg_tp_present = 1'b1;
        pv_read(5'd4, 3'd2, 1'b1, d, inv);
        check(d == TPVAL, "R2 absent write dropped", d, TPVAL);

        // R8: invalid selects and registers
        pv_write(5'd4, 3'd1, 1'b1, 64'h1111_2222_3333_4444);
        pv_read(5'd4, 3'd1, 1'b1, d, inv);
        check(inv && d == '0, "R8 reg4 sel1 invalid", d, '0);
        pv_write(5'd9, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        pv_read(5'd4, 3'd2, 1'b1, d, inv);
        check(d == TPVAL, "R8 tp untouched", d, TPVAL);
        pv_read(5'd7, 3'd0, 1'b1, d, inv);
        check(d == '0, "R8 mask untouched", d, '0);

        // R7: mask read back, sign-extended
        pv_write(5'd7, 3'd0, 1'b1, 64'h0000_0000_8000_0004);
        pv_read(5'd7, 3'd0, 1'b1, d, inv);
        check(d == 64'hFFFF_FFFF_8000_0004 && !inv, "R7 mask read", d, 64'hFFFF_FFFF_8000_0004);

        // R9: same-cycle mask write is not yet visible
        pv_write(5'd7, 3'd0, 1'b1, '0);
        @(negedge clk);
        pv_wr_en = 1'b1; pv_regnum = 5'd7; pv_sel = 3'd0; pv_wdata = 64'h2000_0000;
        kernel_mode = 1'b0; ur_rd_en = 1'b1; ur_index = 5'd29;
        #5;
        check(ur_fault && !ur_valid, "R9 same-cycle read uses old mask",
              {62'd0, ur_valid, ur_fault}, 64'd1);
        @(posedge clk); #1;
        idle_ports();
        ur_read(1'b0, 5'd29, d, v, f);
        check(v && !f && d == TPVAL, "R9 next-cycle read uses new mask", d, TPVAL);

        // R5 R6 R10 R11: permission table
        for (int i = 0; i < NVEC; i++) begin
            pv_write(5'd7, 3'd0, 1'b1, {32'd0, VEC[i].mask});
            ur_read(VEC[i].kern, VEC[i].idx, d, v, f);
            check(v == VEC[i].ok && f == !VEC[i].ok, "R5 R6 R10 R11 permission",
                  {62'd0, v, f}, {62'd0, VEC[i].ok, !VEC[i].ok});
            if (!VEC[i].ok)
                check(d == '0, "R6 faulted data zero", d, '0);
            else if (VEC[i].is_tp)
                check(d == TPVAL, "R5 user read value", d, TPVAL);
        end

        // R11: counter advances one per cycle
        @(negedge clk);
        kernel_mode = 1'b1; ur_rd_en = 1'b1; ur_index = 5'd2;
        #5 d = ur_rdata;
        @(negedge clk); #5 d2 = ur_rdata;
        check(d2 - d == 64'd1 && d2[63:32] == '0, "R11 counter step", d2 - d, 64'd1);
        @(posedge clk); #1;
        idle_ports();

        done = 1'b1;
        finish_run();
    end
endmodule